// File: doc/BRIEF.md
# Grouped Event Select Matrix

This block decides which raw event drives each event counter. The raw events form a matrix of 8 groups (columns). Each group holds 256 codes (rows), so there are 2048 strobes. Every cycle the strobes arrive as one flat vector, and group `g`, code `c` sits at bit `g*256 + c`. A 64-bit selection register holds one 8-bit code for each group. From each group's row, a mux picks the strobe of that group's selected code. A small routing stage then gives each counter the picked strobe of the group named in that counter's type register. The result is registered and appears as one increment pulse per counter.

The selection is shared. A group can watch only one code at a time. Every counter tied to a group therefore sees the same code, and rewriting that group's field retargets all of those counters together. Each counter also has a filter register that can shut its events off. Software sets everything up through a simple write-only register port addressed by a 12-bit address. Counting and overflow handling belong to the counters downstream.

Top module: `evsel_matrix`

## Requirements
- R1: While `rst_ni` is low, and after release until the first register write, `pulse_o` is all zero whatever `strobe_i` carries. Reset clears the selection register, every type register and every filter register.
- R2: `pulse_o[n]` is set one clock after a cycle in which all of these hold:
  - bit 63 of the selection register is set;
  - counter n's filter is nonzero;
  - counter n's group g = type[3:0] is below 8;
  - strobe bit `g*256 + c` is high, where c = selection bits [8g+7:8g].

  Otherwise `pulse_o[n]` is zero.
- R3: With bit 63 of the selection register clear, `pulse_o` stays all zero. Bit 63 also serves as the top bit of group 7's code, so while enabled, group 7 can only select codes 0x80 to 0xFF.
- R4: All counters whose type registers name the same group follow the one code held for that group. Writing a new code into that group's field moves every one of those counters to the new code at once.
- R5: Counter n's filter register sits at address 0x423 + 0x10*n and is 32 bits wide. A value of zero blocks all of the counter's events. Any nonzero value passes them; 0x000E0007 is the value for accepting every origin.
- R6: Counter n's type register sits at address 0x424 + 0x10*n. Only bits [3:0] are used, and the values 8 to 15 name no group, so the counter gets no pulses.
- R7: A register write takes effect at the clock edge that samples it. Strobes presented in that same cycle are routed with the old settings, and strobes in the following cycle use the new settings.
- R8: The selection register sits at 0x410. Writes to any address other than the selection, type and filter registers change nothing, and neither does any cycle with `wr_en_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write address |
| wr_data_i | input | 64 | Register write data |
| strobe_i | input | 2048 | Raw event strobes, group g code c at bit g*256+c |
| pulse_o | output | 8 | Registered increment pulse for each counter |

## Verification
Two functions can land in the same cycle: a register write that retargets routing, and a strobe that the old routing should still count. The bench provokes this by rewriting a group's code while only the old code's strobe is high. It expects a pulse from the old code one cycle later and none on the next cycle. Random runs mix occasional writes with dense random strobes, so such collisions also occur many times without being arranged. A bench model applies each write only after predicting that cycle's pulses, and that model judges every cycle.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned FILT_W = 32;
  localparam int unsigned EN_BIT = 63;

  localparam logic [ADDR_W-1:0] SEL_ADDR   = 12'h410;
  localparam logic [ADDR_W-1:0] CTR_BASE   = 12'h420;
  localparam logic [ADDR_W-1:0] CTR_STRIDE = 12'h010;
  localparam logic [3:0]        FILT_OFF   = 4'h3;
  localparam logic [3:0]        TYPE_OFF   = 4'h4;

  function automatic logic [ADDR_W-1:0] ctr_addr(input int unsigned n, input logic [3:0] off);
    return CTR_BASE + ADDR_W'(n) * CTR_STRIDE + {{(ADDR_W-4){1'b0}}, off};
  endfunction
endpackage

// File: rtl/evsel_regs.sv
module evsel_regs
  import evsel_pkg::*;
#(
  parameter int unsigned NUM_CTRS = 8,
  parameter int unsigned GRP_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  output logic [DATA_W-1:0]         sel_o,
  output logic [NUM_CTRS*GRP_W-1:0] grp_o,
  output logic [NUM_CTRS-1:0]       filt_nz_o
);
  logic [DATA_W-1:0] sel_q;
  logic              sel_hit;

  assign sel_hit = wr_en_i && (wr_addr_i == SEL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (sel_hit) sel_q <= wr_data_i;
  end
  assign sel_o = sel_q;

  for (genvar n = 0; n < NUM_CTRS; n++) begin : g_ctr
    logic             type_hit, filt_hit;
    logic [GRP_W-1:0] grp_q;
    logic             filt_q;  // only "nonzero" matters, so one bit is kept

    assign type_hit = wr_en_i && (wr_addr_i == ctr_addr(n, TYPE_OFF));
    assign filt_hit = wr_en_i && (wr_addr_i == ctr_addr(n, FILT_OFF));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        grp_q  <= '0;
        filt_q <= 1'b0;
      end else begin
        if (type_hit) grp_q  <= wr_data_i[GRP_W-1:0];
        if (filt_hit) filt_q <= |wr_data_i[FILT_W-1:0];
      end
    end

    assign grp_o[n*GRP_W +: GRP_W] = grp_q;
    assign filt_nz_o[n]            = filt_q;
  end
endmodule

// File: rtl/evsel_group_mux.sv
module evsel_group_mux #(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned CODE_W     = 8,
  localparam int unsigned NUM_CODES = 1 << CODE_W
) (
  input  logic [NUM_GROUPS*NUM_CODES-1:0] strobe_i,
  input  logic [NUM_GROUPS*CODE_W-1:0]    code_i,
  output logic [NUM_GROUPS-1:0]           grp_ev_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [NUM_CODES-1:0] row;
    logic [CODE_W-1:0]    code;
    assign row         = strobe_i[g*NUM_CODES +: NUM_CODES];
    assign code        = code_i[g*CODE_W +: CODE_W];
    assign grp_ev_o[g] = row[code];
  end
endmodule

// File: rtl/evsel_route.sv
module evsel_route #(
  parameter int unsigned NUM_CTRS   = 8,
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned GRP_W      = 4,
  localparam int unsigned PAD       = 1 << GRP_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic [NUM_GROUPS-1:0]     grp_ev_i,
  input  logic [NUM_CTRS*GRP_W-1:0] grp_i,
  input  logic [NUM_CTRS-1:0]       filt_nz_i,
  output logic [NUM_CTRS-1:0]       pulse_o
);
  // Unused group numbers index zero padding.
  logic [PAD-1:0] ev_pad;
  assign ev_pad = PAD'(grp_ev_i);

  for (genvar n = 0; n < NUM_CTRS; n++) begin : g_ctr
    logic [GRP_W-1:0] grp;
    logic             hit, pulse_q;

    assign grp = grp_i[n*GRP_W +: GRP_W];
    assign hit = en_i && filt_nz_i[n] && ev_pad[grp];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= hit;
    end
    assign pulse_o[n] = pulse_q;
  end
endmodule

// File: rtl/evsel_matrix.sv
module evsel_matrix
  import evsel_pkg::*;
#(
  parameter int unsigned NUM_CTRS   = 8,
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned GRP_W      = 4,
  localparam int unsigned NUM_CODES = 1 << CODE_W,
  localparam int unsigned STROBE_W  = NUM_GROUPS * NUM_CODES,
  localparam int unsigned CODES_W   = NUM_GROUPS * CODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [STROBE_W-1:0] strobe_i,
  output logic [NUM_CTRS-1:0] pulse_o
);
  logic [DATA_W-1:0]         sel_w;
  logic [NUM_CTRS*GRP_W-1:0] grp_w;
  logic [NUM_CTRS-1:0]       filt_nz_w;
  logic [NUM_GROUPS-1:0]     grp_ev_w;

  evsel_regs #(.NUM_CTRS(NUM_CTRS), .GRP_W(GRP_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sel_o     (sel_w),
    .grp_o     (grp_w),
    .filt_nz_o (filt_nz_w)
  );

  // Code fields pack from bit 0; the top field shares its msb with the enable bit.
  evsel_group_mux #(.NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W)) u_mux (
    .strobe_i (strobe_i),
    .code_i   (sel_w[CODES_W-1:0]),
    .grp_ev_o (grp_ev_w)
  );

  evsel_route #(.NUM_CTRS(NUM_CTRS), .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_route (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (sel_w[EN_BIT]),
    .grp_ev_i  (grp_ev_w),
    .grp_i     (grp_w),
    .filt_nz_i (filt_nz_w),
    .pulse_o   (pulse_o)
  );
endmodule

// File: rtl/evsel_matrix_chk.sv
module evsel_matrix_chk
  import evsel_pkg::*;
#(
  parameter int unsigned NUM_CTRS   = 8,
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned GRP_W      = 4,
  localparam int unsigned NUM_CODES = 1 << CODE_W
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [DATA_W-1:0]                 sel_i,
  input logic [NUM_CTRS*GRP_W-1:0]         grp_i,
  input logic [NUM_CTRS-1:0]               filt_i,
  input logic [NUM_GROUPS*NUM_CODES-1:0]   strobe_i,
  input logic [NUM_CTRS-1:0]               pulse_i
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) rst_quiet_chk: assert (pulse_i == '0);
  end

  // R3
  disable_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i[EN_BIT] |=> (pulse_i == '0));

  for (genvar n = 0; n < NUM_CTRS; n++) begin : g_ctr
    logic [GRP_W-1:0] g;
    logic             g_ok, ev;
    assign g    = grp_i[n*GRP_W +: GRP_W];
    assign g_ok = {1'b0, g} < (GRP_W+1)'(NUM_GROUPS);
    always_comb begin
      ev = 1'b0;
      for (int k = 0; k < NUM_GROUPS; k++)
        if (g == GRP_W'(k)) ev = strobe_i[k*NUM_CODES + int'(sel_i[k*CODE_W +: CODE_W])];
    end

    // R5
    filt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !filt_i[n] |=> !pulse_i[n]);

    // R6
    bad_group_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !g_ok |=> !pulse_i[n]);

    // R2
    route_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[EN_BIT] && filt_i[n] && g_ok && ev) |=> pulse_i[n]);
  end
endmodule

bind evsel_matrix evsel_matrix_chk #(
  .NUM_CTRS(NUM_CTRS), .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W), .GRP_W(GRP_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_w),
  .grp_i    (grp_w),
  .filt_i   (filt_nz_w),
  .strobe_i (strobe_i),
  .pulse_i  (pulse_o)
);

// File: tb/evsel_matrix_bench.sv
`timescale 1ns/1ps
module evsel_matrix_bench;
  localparam int NC = 8, NG = 8, NCODE = 256, SW = NG * NCODE;

  logic          clk = 1'b0, rst_ni = 1'b0, wr_en = 1'b0;
  logic [11:0]   wr_addr = '0;
  logic [63:0]   wr_data = '0;
  logic [SW-1:0] strobe = '0;
  logic [NC-1:0] pulse;

  always #2.5 clk = ~clk;

  evsel_matrix u_evsel_matrix (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .strobe_i(strobe), .pulse_o(pulse)
  );

  int checks = 0, fails = 0;
  logic [63:0]   m_sel = '0;
  logic [3:0]    m_grp [NC];
  bit            m_filt [NC];
  logic [NC-1:0] exp_q;
  string         exp_tag;
  bit            have_exp = 0;

  function automatic logic [NC-1:0] model_pulse(input logic [SW-1:0] s);
    logic [NC-1:0] r = '0;
    for (int n = 0; n < NC; n++) begin
      int g = int'(m_grp[n]);
      if (m_sel[63] && m_filt[n] && g < NG) r[n] = s[g*NCODE + int'(m_sel[g*8 +: 8])];
    end
    return r;
  endfunction

  task automatic model_write(input bit we, input logic [11:0] a, input logic [63:0] d);
    if (!we) return;
    if (a == 12'h410) m_sel = d;
    for (int n = 0; n < NC; n++) begin
      if (a == 12'h424 + 12'(n*16)) m_grp[n] = d[3:0];
      if (a == 12'h423 + 12'(n*16)) m_filt[n] = (d[31:0] != 0);
    end
  endtask

  task automatic check(input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pulse_o actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit we, input logic [11:0] a,
                      input logic [63:0] d, input logic [SW-1:0] s);
    @(negedge clk);
    if (have_exp) check(exp_tag, pulse, exp_q);
    wr_en = we; wr_addr = a; wr_data = d; strobe = s;
    exp_q = model_pulse(s);  // routing of this cycle uses pre-write state (R7)
    exp_tag = tag;
    have_exp = 1;
    model_write(we, a, d);
  endtask

  function automatic logic [SW-1:0] one_hot(input int g, input int c);
    logic [SW-1:0] r = '0;
    r[g*NCODE + c] = 1'b1;
    return r;
  endfunction

  function automatic logic [SW-1:0] rand_strobe();
    logic [SW-1:0] r;
    for (int w = 0; w < SW/32; w++) r[w*32 +: 32] = $urandom();
    return r;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [63:0] sel_cfg, sel_tmp;
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < NC; n++) begin m_grp[n] = '0; m_filt[n] = 0; end

    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      strobe = '1;
      check("R1 in reset", pulse, '0);
    end
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) step("R1 after reset", 0, '0, '0, '1);

    // setup: pass filters, counter n on group n
    for (int n = 0; n < NC; n++) step("R5 setup", 1, 12'h423 + 12'(n*16), 64'h000E_0007, '1);
    for (int n = 0; n < NC; n++) step("R2 setup", 1, 12'h424 + 12'(n*16), 64'(n), '1);
    sel_cfg = '0;
    for (int g = 0; g < NG; g++) sel_cfg[g*8 +: 8] = 8'(g*37 + 1);
    sel_cfg[63] = 1'b1;
    step("R2 setup", 1, 12'h410, sel_cfg, '1);

    // R2: directed hits and near misses per group
    for (int g = 0; g < NG; g++) begin
      step("R2 hit", 0, '0, '0, one_hot(g, int'(sel_cfg[g*8 +: 8])));
      step("R2 miss", 0, '0, '0, one_hot(g, int'(sel_cfg[g*8 +: 8] ^ 8'h01)));
    end

    // R8: no-op writes
    step("R8 wr_en low", 0, 12'h410, 64'h0, '1);
    step("R8 stray 0x411", 1, 12'h411, 64'h0, '1);
    step("R8 stray 0x425", 1, 12'h425, 64'h9, '1);
    step("R8 stray 0x4A4", 1, 12'h4A4, 64'h9, '1);
    step("R8 stray 0x4A3", 1, 12'h4A3, 64'h0, '1);
    step("R8 after stray", 0, '0, '0, '1);

    // R3: enable clear; group 7 msb shares bit 63
    sel_tmp = sel_cfg; sel_tmp[63] = 1'b0;
    step("R3 disable", 1, 12'h410, sel_tmp, '1);
    step("R3 disabled", 0, '0, '0, '1);
    step("R3 disabled g7", 0, '0, '0, one_hot(7, int'(sel_tmp[63:56])));
    step("R3 reenable", 1, 12'h410, sel_cfg, '1);
    step("R3 enabled", 0, '0, '0, '1);

    // R4: counters 0,1,2 share group 2
    step("R4 setup", 1, 12'h424, 64'h2, '0);
    step("R4 setup", 1, 12'h434, 64'h2, '0);
    step("R4 shared", 0, '0, '0, one_hot(2, int'(sel_cfg[23:16])));
    sel_tmp = sel_cfg; sel_tmp[23:16] = 8'hAA;
    step("R4 retarget", 1, 12'h410, sel_tmp, '0);
    step("R4 old code", 0, '0, '0, one_hot(2, int'(sel_cfg[23:16])));
    step("R4 new code", 0, '0, '0, one_hot(2, 8'hAA));

    // R5: filter blocks counter 3
    step("R5 block", 1, 12'h453, 64'h0, '1);
    step("R5 blocked", 0, '0, '0, '1);
    step("R5 pass", 1, 12'h453, 64'h1_0000_0000_0100, '1);
    step("R5 passing", 0, '0, '0, '1);

    // R6: type field decode for counter 4
    step("R6 group 8", 1, 12'h464, 64'h8, '1);
    step("R6 group 15", 1, 12'h464, 64'hF, '1);
    step("R6 hi bits 0x1A", 1, 12'h464, 64'h1A, '1);
    step("R6 hi bits 0x13", 1, 12'h464, 64'h13, '1);
    step("R6 valid", 0, '0, '0, '1);

    // R7: write and strobe in the same cycle
    sel_tmp[47:40] = 8'h33;
    step("R7 same cycle", 1, 12'h410, sel_tmp, one_hot(5, int'(sel_cfg[47:40])));
    step("R7 next old", 0, '0, '0, one_hot(5, int'(sel_cfg[47:40])));
    step("R7 next new", 0, '0, '0, one_hot(5, 8'h33));

    // R2: random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 15);
      int unsigned n = $urandom_range(0, NC-1);
      logic [63:0] d = {$urandom(), $urandom()};
      case (r)
        0: begin d[63] = ($urandom_range(0, 7) != 0); step("R2 random sel", 1, 12'h410, d, rand_strobe()); end
        1: step("R2 random type", 1, 12'h424 + 12'(n*16), 64'($urandom_range(0, 9)), rand_strobe());
        2: step("R2 random filt", 1, 12'h423 + 12'(n*16), ($urandom_range(0, 3) == 0) ? 64'h0 : d, rand_strobe());
        3: step("R2 random addr", 1, 12'($urandom()), d, rand_strobe());
        default: step("R2 random", 0, '0, '0, rand_strobe());
      endcase
    end
    @(negedge clk);
    if (have_exp) check(exp_tag, pulse, exp_q);
    finish_run();
  end
endmodule